// File: doc/BRIEF.md
# Multi-CPU level interrupt router

This block collects a parameterised number of level-sensitive peripheral interrupt lines (64, 96, 128 or 160, i.e. two to five 32-bit words) and steers them toward several CPUs. Every CPU owns a complete private bank of mask state. Each CPU's interrupt output is the OR of all lines that are currently high and unmasked in that CPU's bank. Any line can therefore be enabled toward any subset of CPUs. No edge, polarity, priority or vector logic is involved. Software scans the status words of its own bank to find the active sources.

Masks change only through atomic write-one-to-set and write-one-to-clear words, so no read-modify-write sequence is ever needed. Peripheral lines pass through a two-flop synchroniser before any use.

The register bus is a simple single-cycle strobe interface. The word address is `{cpu_select, bank_offset}`. Read data appears on the cycle after the read strobe.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset every mask bit of every CPU bank is 1, `irq_out` is all zero and `bus_rdata` is zero, even while inputs are high.
- R2: A read at bank offset w (0 <= w < W, where W = NUM_LINES/32) returns the synchronised levels of lines 32w to 32w+31, with bit b holding line 32w+b.
- R3: A read at bank offset W+w returns the status word w AND NOT the mask word w of the addressed CPU.
- R4: A write at bank offset 2W+w sets the mask bits of word w that are 1 in the write data; bits written 0 keep their value.
- R5: A write at bank offset 3W+w clears the mask bits of word w that are 1 in the write data; bits written 0 keep their value.
- R6: Reads of the set and clear offsets, of offsets at or above 4W, or of a CPU select at or above NUM_CPUS return 0. Writes to status, masked-status or out-of-range addresses change no mask.
- R7: `irq_out[c]` is 1 exactly when some line is high and unmasked in bank c. It follows an input change after two clock edges of synchronisation and drops as soon as the synchronised level drops.
- R8: A write addressed to one CPU never changes another CPU's mask state.
- R9: `bus_rdata` carries the read result on the cycle after `bus_rd` and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Level-sensitive peripheral interrupt lines |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | CPU_AW+BANK_AW | Word address, `{cpu_select, bank_offset}` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
The assertions assume that reset is held for at least one clock before the first check. They also assume that `bus_wr` and `bus_rd` are never asserted while reset is active, and that `irq_in` is treated as a level with no relation to the clock. The stimulus drives every input on the falling edge, so each value is stable for a full cycle around the sampling edge. It issues at most one bus operation per strobe cycle and only asserts strobes after reset has been released. Input patterns change only between bus operations, so each masked-status read has a single well-defined expected value under the two-edge synchroniser latency.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    GRP_STATUS  = 2'd0,
    GRP_PENDING = 2'd1,
    GRP_SET     = 2'd2,
    GRP_CLEAR   = 2'd3
  } grp_e;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank
  import lvl_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int W      = NUM_LINES / WORD_W,
  localparam int WSEL_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  grp_e                 grp,
  input  logic [WSEL_W-1:0]    word,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] raw,
  output logic [NUM_LINES-1:0] mask,
  output logic                 irq
);
  // Atomic set/clear: only bits written as 1 move, per addressed word.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
    end else if (wr_en) begin
      for (int w = 0; w < W; w++) begin
        if (word == WSEL_W'(w)) begin
          if (grp == GRP_SET)
            mask[w*WORD_W +: WORD_W] <= mask[w*WORD_W +: WORD_W] | wdata;
          else if (grp == GRP_CLEAR)
            mask[w*WORD_W +: WORD_W] <= mask[w*WORD_W +: WORD_W] & ~wdata;
        end
      end
    end
  end

  assign irq = |(raw & ~mask);
endmodule

// File: rtl/lvl_irq_rdport.sv
module lvl_irq_rdport
  import lvl_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  localparam int W      = NUM_LINES / WORD_W,
  localparam int WSEL_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  grp_e                 grp,
  input  logic [WSEL_W-1:0]    word,
  input  logic [NUM_LINES-1:0] raw,
  input  logic [NUM_LINES-1:0] mask_sel,
  output logic [WORD_W-1:0]    rdata
);
  logic [WORD_W-1:0] raw_word;
  logic [WORD_W-1:0] mask_word;

  always_comb begin
    raw_word  = '0;
    mask_word = '1;
    for (int w = 0; w < W; w++) begin
      if (word == WSEL_W'(w)) begin
        raw_word  = raw[w*WORD_W +: WORD_W];
        mask_word = mask_sel[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (rd_en) begin
        case (grp)
          GRP_STATUS:  rdata <= raw_word;
          GRP_PENDING: rdata <= raw_word & ~mask_word;
          default:     rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lvl_irq_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int NUM_CPUS  = 3,
  localparam int W        = NUM_LINES / WORD_W,
  localparam int WSEL_W   = (W > 1) ? $clog2(W) : 1,
  localparam int BANK_AW  = $clog2(4 * W),
  localparam int CPU_AW   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int ADDR_W   = CPU_AW + BANK_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_CPUS-1:0]  irq_out
);
  logic [NUM_LINES-1:0]                lvl_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_all;
  logic [CPU_AW-1:0]                   cpu_f;
  logic [BANK_AW-1:0]                  idx_f;
  logic                                cpu_ok;
  logic                                idx_ok;
  grp_e                                grp;
  logic [WSEL_W-1:0]                   word;
  logic [NUM_LINES-1:0]                mask_sel;

  lvl_irq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_in),
    .q   (lvl_q)
  );

  assign cpu_f  = bus_addr[ADDR_W-1 -: CPU_AW];
  assign idx_f  = bus_addr[BANK_AW-1:0];
  assign cpu_ok = (32'(cpu_f) < NUM_CPUS);

  // Offset -> (group, word): groups of W words in order status, pending, set, clear.
  always_comb begin
    int unsigned iv;
    iv     = 32'(idx_f);
    idx_ok = 1'b1;
    grp    = GRP_STATUS;
    word   = '0;
    if (iv < W) begin
      grp  = GRP_STATUS;
      word = WSEL_W'(iv);
    end else if (iv < 2 * W) begin
      grp  = GRP_PENDING;
      word = WSEL_W'(iv - W);
    end else if (iv < 3 * W) begin
      grp  = GRP_SET;
      word = WSEL_W'(iv - 2 * W);
    end else if (iv < 4 * W) begin
      grp  = GRP_CLEAR;
      word = WSEL_W'(iv - 3 * W);
    end else begin
      idx_ok = 1'b0;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
      lvl_irq_bank #(.NUM_LINES(NUM_LINES)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && idx_ok && (cpu_f == CPU_AW'(c))),
        .grp   (grp),
        .word  (word),
        .wdata (bus_wdata),
        .raw   (lvl_q),
        .mask  (mask_all[c]),
        .irq   (irq_out[c])
      );
    end
  endgenerate

  always_comb begin
    mask_sel = '1;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (cpu_f == CPU_AW'(c)) mask_sel = mask_all[c];
    end
  end

  lvl_irq_rdport #(.NUM_LINES(NUM_LINES)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd && idx_ok && cpu_ok),
    .grp      (grp),
    .word     (word),
    .raw      (lvl_q),
    .mask_sel (mask_sel),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/lvl_irq_router_chk.sv
module lvl_irq_router_chk #(
  parameter int NUM_LINES = 96,
  parameter int NUM_CPUS  = 3,
  localparam int W        = NUM_LINES / 32,
  localparam int BANK_AW  = $clog2(4 * W),
  localparam int CPU_AW   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int ADDR_W   = CPU_AW + BANK_AW
) (
  input logic                                clk,
  input logic                                rst,
  input logic [NUM_LINES-1:0]                irq_in,
  input logic                                bus_wr,
  input logic                                bus_rd,
  input logic [ADDR_W-1:0]                   bus_addr,
  input logic [31:0]                         bus_rdata,
  input logic [NUM_CPUS-1:0]                 irq_out,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0] mask_all
);
  logic [CPU_AW-1:0] a_cpu;
  int unsigned       a_idx;
  logic              in_set;
  logic              in_clr;
  logic              no_effect;

  assign a_cpu     = bus_addr[ADDR_W-1 -: CPU_AW];
  assign a_idx     = 32'(bus_addr[BANK_AW-1:0]);
  assign in_set    = (a_idx >= 2 * W) && (a_idx < 3 * W);
  assign in_clr    = (a_idx >= 3 * W) && (a_idx < 4 * W);
  assign no_effect = (a_idx < 2 * W) || (a_idx >= 4 * W);

  // R1: reset leaves every output quiet.
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && bus_rdata == '0));

  // R9: read data is zero outside the cycle after a read strobe.
  p_rd_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

  // R7: no interrupt while all inputs were low two edges earlier.
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_in, 2) == '0) |-> irq_out == '0);

  generate
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      // R4: a set write never clears a mask bit.
      p_set_no_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a_cpu == CPU_AW'(c) && in_set) |=>
          ((mask_all[c] & $past(mask_all[c])) == $past(mask_all[c])));

      // R5: a clear write never sets a mask bit.
      p_clr_no_set_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a_cpu == CPU_AW'(c) && in_clr) |=>
          ((mask_all[c] | $past(mask_all[c])) == $past(mask_all[c])));

      // R6: writes to read-only or unmapped offsets leave masks alone.
      p_ro_write_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && no_effect) |=> $stable(mask_all[c]));

      // R8: writes to other banks leave this bank alone.
      p_other_bank_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a_cpu != CPU_AW'(c)) |=> $stable(mask_all[c]));

      // R6: without any write the mask holds.
      p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(mask_all[c]));
    end
  endgenerate
endmodule

bind lvl_irq_router lvl_irq_router_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_CPUS  (NUM_CPUS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_in    (irq_in),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .mask_all  (mask_all)
);

// File: tb/sim_lvl_irq_router.sv
module sim_lvl_irq_router;
  localparam int L  = 96;
  localparam int C  = 3;
  localparam int W  = L / 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [L-1:0]  irq_in = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [C-1:0]  irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  always #4 clk = ~clk;

  lvl_irq_router #(.NUM_LINES(L), .NUM_CPUS(C)) u0 (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  // Behavioural reference model.
  logic [L-1:0] m_s1, m_s2;
  logic [L-1:0] m_mask [C];
  logic [31:0]  m_rd;

  function automatic logic [31:0] model_read(int cpu, int idx);
    if (cpu >= C || idx >= 4 * W) return 32'h0;
    if (idx < W) return m_s2[idx*32 +: 32];
    if (idx < 2 * W) return m_s2[(idx-W)*32 +: 32] & ~m_mask[cpu][(idx-W)*32 +: 32];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0;
      m_s2 <= '0;
      m_rd <= '0;
      for (int c = 0; c < C; c++) m_mask[c] <= '1;
    end else begin
      int cpu, idx;
      cpu  = int'(bus_addr[5:4]);
      idx  = int'(bus_addr[3:0]);
      m_s1 <= irq_in;
      m_s2 <= m_s1;
      m_rd <= bus_rd ? model_read(cpu, idx) : 32'h0;
      if (bus_wr && cpu < C) begin
        if (idx >= 2 * W && idx < 3 * W)
          m_mask[cpu][(idx-2*W)*32 +: 32] <= m_mask[cpu][(idx-2*W)*32 +: 32] | bus_wdata;
        else if (idx >= 3 * W && idx < 4 * W)
          m_mask[cpu][(idx-3*W)*32 +: 32] <= m_mask[cpu][(idx-3*W)*32 +: 32] & ~bus_wdata;
      end
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (live && !done) begin
      logic [C-1:0] e_irq;
      for (int c = 0; c < C; c++) e_irq[c] = |(m_s2 & ~m_mask[c]);
      n_chk++;
      if (irq_out !== e_irq) begin
        n_fail++;
        $display("FAIL R7 irq_out actual=%b expected=%b", irq_out, e_irq);
      end
      n_chk++;
      if (bus_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R9 bus_rdata actual=%h expected=%h", bus_rdata, m_rd);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int cpu, int idx, logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = {2'(cpu), 4'(idx)};
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(int cpu, int idx, output logic [31:0] d);
    @(negedge clk);
    bus_rd   = 1'b1;
    bus_addr = {2'(cpu), 4'(idx)};
    @(negedge clk);
    bus_rd = 1'b0;
    d      = bus_rdata;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    settle(4);
    rst  = 1'b0;
    live = 1'b1;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 irq after reset", 32'(irq_out), 32'h0);

    // R1: all lines high but all masked.
    irq_in = '1;
    settle(3);
    check("R1 irq masked", 32'(irq_out), 32'h0);
    rd(0, W, d);  check("R1 pending masked", d, 32'h0);

    // R2: status words reflect synchronised inputs.
    irq_in = {32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_0F0F};
    settle(3);
    rd(1, 0, d);  check("R2 status w0", d, 32'hA5A5_0F0F);
    rd(1, 1, d);  check("R2 status w1", d, 32'h1234_5678);
    rd(2, 2, d);  check("R2 status w2", d, 32'hDEAD_BEEF);

    // R5: unmask low byte on CPU0.
    wr(0, 3 * W, 32'h0000_00FF);
    rd(0, W, d);  check("R3 R5 pending after clear", d, 32'h0000_000F);
    check("R7 irq cpu0 only", 32'(irq_out), 32'h1);
    rd(1, W, d);  check("R8 cpu1 untouched", d, 32'h0);

    // R4: set bits 2,3; then a zero write changes nothing.
    wr(0, 2 * W, 32'h0000_000C);
    rd(0, W, d);  check("R4 pending after set", d, 32'h0000_0003);
    wr(0, 2 * W, 32'h0);
    rd(0, W, d);  check("R4 zero bits unchanged", d, 32'h0000_0003);

    // R6: ignored writes and zero reads.
    wr(3, 3 * W, 32'hFFFF_FFFF);
    wr(1, 0, 32'hFFFF_FFFF);
    wr(1, W, 32'hFFFF_FFFF);
    wr(1, 13, 32'hFFFF_FFFF);
    rd(1, W, d);      check("R6 cpu1 still masked", d, 32'h0);
    rd(2, W + 1, d);  check("R6 cpu2 still masked", d, 32'h0);
    rd(0, 2 * W, d);  check("R6 set reads zero", d, 32'h0);
    rd(0, 3 * W, d);  check("R6 clear reads zero", d, 32'h0);
    rd(0, 14, d);     check("R6 unmapped offset", d, 32'h0);
    rd(3, 0, d);      check("R6 unmapped cpu", d, 32'h0);
    rd(0, W, d);      check("R6 cpu0 unchanged", d, 32'h0000_0003);
    check("R6 irq unchanged", 32'(irq_out), 32'h1);

    // R7: line 95 to CPU2, then drop it and watch latency.
    wr(2, 3 * W + 2, 32'h8000_0000);
    check("R7 cpu2 raised", 32'(irq_out), 32'h5);
    @(negedge clk);
    irq_in[95] = 1'b0;
    settle(1);
    check("R7 one edge later still high", 32'(irq_out), 32'h5);
    settle(1);
    check("R7 dropped after sync", 32'(irq_out), 32'h1);

    // R8: unmask all of CPU1, CPU0 and CPU2 keep their masks.
    for (int w = 0; w < W; w++) wr(1, 3 * W + w, 32'hFFFF_FFFF);
    rd(1, W + 1, d);      check("R8 cpu1 pending w1", d, 32'h1234_5678);
    rd(0, W + 1, d);      check("R8 cpu0 w1 masked", d, 32'h0);
    rd(2, W + 2, d);      check("R8 cpu2 w2", d, 32'h0);
    check("R8 irq pattern", 32'(irq_out), 32'h3);

    irq_in = '0;
    settle(3);
    check("R7 all quiet", 32'(irq_out), 32'h0);
    settle(2);
    done = 1'b1;
    finish_run();
  end
endmodule